// File: doc/BRIEF.md
# I2C Command Framer

This block is the slave side of a two-wire serial bus, built to run entirely in a fast system clock domain. Both bus lines are resynchronised and cleaned of short spikes before any decoding. The block watches for START and STOP conditions and compares the incoming 7-bit address against a fixed `1110` prefix. Three strap inputs supply the low address bits, so up to eight of these slaves can share one bus.

A write transfer carries exactly two data bytes after the address. The block acknowledges each of them and delivers the pair as one 16-bit command word with a single-cycle valid strobe. A read transfer returns a zero byte followed by a byte sampled from a parallel status input. The slave never drives the data line high: it only asserts an open-drain enable that pulls SDA low. A repeated START abandons whatever transfer is in progress and evaluates a new address.

Top module: `i2c_cmd_framer`

## Requirements
- R1: The slave acknowledges, by pulling SDA low during the ninth SCL pulse, only an address byte whose upper seven bits (sent MSB first) equal `1110` followed by `addr_pins_i[2:0]`. The last bit of the address byte is the direction: 1 means read, 0 means write.
- R2: After an address that does not match, the slave never drives SDA and produces no command until the next START.
- R3: In a write, both data bytes are acknowledged. `cmd_o` becomes {first byte, second byte}, with the first byte in bits 15:8. `cmd_o` changes only in the cycle where `cmd_valid_o` is high.
- R4: `cmd_valid_o` is high for exactly one system clock per completed two-byte write, after the second byte has been acknowledged.
- R5: A STOP or START that arrives after only one data byte discards the partial word, and no strobe is produced.
- R6: Data bytes written after the second are not acknowledged and produce no further strobe.
- R7: A read returns 0x00 first and then `status_i`, each MSB first. The second byte is sent only if the master acknowledged the first.
- R8: When the master leaves SDA high on the ninth clock after a read byte (NACK), the slave stops driving SDA for the rest of the transfer.
- R9: A repeated START resets the bit count and re-evaluates the address, whatever state the transfer was in.
- R10: A pulse on SCL or SDA shorter than `FILT_LEN` system clocks is ignored. This holds for a spike that would otherwise add a clock or form a false START.
- R11: While reset is asserted, `sda_oe_o` and `cmd_valid_o` are 0, and after reset `cmd_o` is 0.
- R12: The slave changes the level it drives onto SDA only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_pins_i | input | 3 | Strap value for the low three address bits |
| status_i | input | 8 | Byte returned as the second read byte |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| cmd_o | output | 16 | Last completed command word |
| cmd_valid_o | output | 1 | One-cycle strobe when a command completes |

## Verification
The hardest situations to reach are the bus events that never occur on a clean bus. These include a spike on SDA during SCL high that looks like a START, an extra SCL spike inside a low phase, and a repeated START that lands right after a rejected address or a half-finished write. The bench drives the bus through a behavioural master whose bit task can inject these sub-filter spikes on demand, and it sequences repeated STARTs straight out of the acknowledge phase. A reference monitor tracks on every clock the windows in which the slave may pull SDA low, and it counts every strobe against a queue of expected command words.

// File: rtl/i2c_cf_pkg.sv
package i2c_cf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK
  } cf_state_e;
  localparam logic [3:0] ADDR_PREFIX = 4'b1110;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CMD_W  = 2 * BYTE_W;
endpackage

// File: rtl/i2c_cf_filter.sv
module i2c_cf_filter #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [1:0]          sync_q;
  logic [FILT_LEN-1:0] win_q;

  // output moves only when the whole window agrees
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      win_q  <= '1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      win_q  <= {win_q[FILT_LEN-2:0], sync_q[1]};
      if (&win_q)       line_o <= 1'b1;
      else if (~|win_q) line_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_cf_fsm.sv
module i2c_cf_fsm
  import i2c_cf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        addr_pins_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              sda_oe_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              cmd_valid_o,
  output logic              idle_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);

  cf_state_e         state_q;
  logic              scl_q, sda_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] shift_q, hold_q, tx_q;
  logic              rw_q, byte_idx_q, mack_q;

  logic scl_rise, scl_fall, start_c, stop_c, byte_done;
  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_c   = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_c    = scl_i & scl_q & ~sda_q & sda_i;
  assign byte_done = (bit_cnt_q == CNT_W'(BYTE_W));
  assign idle_o    = (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      scl_q       <= 1'b1;
      sda_q       <= 1'b1;
      bit_cnt_q   <= '0;
      shift_q     <= '0;
      hold_q      <= '0;
      tx_q        <= '0;
      rw_q        <= 1'b0;
      byte_idx_q  <= 1'b0;
      mack_q      <= 1'b0;
      sda_oe_o    <= 1'b0;
      cmd_o       <= '0;
      cmd_valid_o <= 1'b0;
    end else begin
      scl_q       <= scl_i;
      sda_q       <= sda_i;
      cmd_valid_o <= 1'b0;
      if (start_c) begin
        state_q    <= ST_ADDR;
        bit_cnt_q  <= '0;
        byte_idx_q <= 1'b0;
        sda_oe_o   <= 1'b0;
      end else if (stop_c) begin
        state_q    <= ST_IDLE;
        byte_idx_q <= 1'b0;
        sda_oe_o   <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              shift_q   <= {shift_q[BYTE_W-2:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall && byte_done) begin
              if (state_q == ST_WR) begin
                sda_oe_o <= 1'b1;
                if (!byte_idx_q) hold_q <= shift_q;
                state_q <= ST_WACK;
              end else if (shift_q[BYTE_W-1:1] == {ADDR_PREFIX, addr_pins_i}) begin
                sda_oe_o <= 1'b1;
                rw_q     <= shift_q[0];
                state_q  <= ST_AACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            bit_cnt_q <= '0;
            if (rw_q) begin
              tx_q     <= '0;         // first read byte is zero
              sda_oe_o <= 1'b1;
              state_q  <= ST_RD;
            end else begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_WR;
            end
          end
          ST_WACK: if (scl_fall) begin
            sda_oe_o  <= 1'b0;
            bit_cnt_q <= '0;
            if (byte_idx_q) begin
              cmd_o       <= {hold_q, shift_q};
              cmd_valid_o <= 1'b1;
              state_q     <= ST_IDLE;
            end else begin
              byte_idx_q <= 1'b1;
              state_q    <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall) begin
              if (byte_done) begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_RACK;
              end else begin
                sda_oe_o <= ~tx_q[BYTE_W-2];
                tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_i;
            end else if (scl_fall) begin
              if (mack_q && !byte_idx_q) begin
                byte_idx_q <= 1'b1;
                bit_cnt_q  <= '0;
                tx_q       <= status_i;
                sda_oe_o   <= ~status_i[BYTE_W-1];
                state_q    <= ST_RD;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_cmd_framer.sv
module i2c_cmd_framer
  import i2c_cf_pkg::*;
#(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        addr_pins_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              sda_oe_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              cmd_valid_o
);
  localparam int unsigned N_LINES = 2;

  logic [N_LINES-1:0] raw_lines, filt_lines;
  logic scl_f, sda_f, fsm_idle;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    i2c_cf_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw_lines[g]),
      .line_o (filt_lines[g])
    );
  end

  assign scl_f = filt_lines[1];
  assign sda_f = filt_lines[0];

  i2c_cf_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_i       (scl_f),
    .sda_i       (sda_f),
    .addr_pins_i (addr_pins_i),
    .status_i    (status_i),
    .sda_oe_o    (sda_oe_o),
    .cmd_o       (cmd_o),
    .cmd_valid_o (cmd_valid_o),
    .idle_o      (fsm_idle)
  );
endmodule

// File: rtl/i2c_cmd_framer_chk.sv
module i2c_cmd_framer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        scl_f,
  input logic        fsm_idle,
  input logic        sda_oe_o,
  input logic [15:0] cmd_o,
  input logic        cmd_valid_o
);
  p_oe_low_scl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_f);

  p_strobe_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  p_cmd_with_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmd_o) |-> cmd_valid_o);

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsm_idle |-> !sda_oe_o);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r11: assert (!sda_oe_o && !cmd_valid_o);
    end
  end
endmodule

bind i2c_cmd_framer i2c_cmd_framer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_f       (scl_f),
  .fsm_idle    (fsm_idle),
  .sda_oe_o    (sda_oe_o),
  .cmd_o       (cmd_o),
  .cmd_valid_o (cmd_valid_o)
);

// File: tb/i2c_cmd_framer_test.sv
module i2c_cmd_framer_test;
  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1, sda_m = 1'b1;
  logic [2:0]  pins = 3'b101;
  logic [7:0]  status = 8'hA6;
  logic        sda_oe, cmd_valid;
  logic [15:0] cmd;
  wire         sda_line = sda_m & ~sda_oe;

  int checks = 0, fails = 0, pulses = 0, viol = 0;
  bit allow = 1'b0, prev_valid = 1'b0, done = 1'b0;
  logic [15:0] exp_q[$];

  always #2 clk = ~clk;

  i2c_cmd_framer uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_pins_i(pins), .status_i(status),
    .sda_oe_o(sda_oe), .cmd_o(cmd), .cmd_valid_o(cmd_valid));

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference monitor: drive windows and strobe queue, every clock
  always @(negedge clk) if (rst_n) begin
    if (sda_oe && !allow) viol++;
    if (cmd_valid) begin
      pulses++;
      if (prev_valid) begin checks++; fails++; $display("FAIL R4 actual=2 expected=1 cycles"); end
      if (exp_q.size() == 0) check(0, "R4 unexpected strobe", cmd, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(cmd == e, "R3 cmd word", cmd, e);
      end
    end
    prev_valid = cmd_valid;
  end

  task automatic w(int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start();
    w(Q); sda_m = 1'b1; w(Q); scl = 1'b1; w(2*Q); sda_m = 1'b0; w(2*Q); scl = 1'b0;
  endtask

  task automatic i2c_stop();
    w(Q); sda_m = 1'b0; w(Q); scl = 1'b1; w(2*Q); sda_m = 1'b1; w(4*Q);
  endtask

  task automatic xfer_bit(input bit b, input bit glitch, output bit seen);
    if (glitch) begin
      w(3); scl = 1'b1; w(2); scl = 1'b0; w(Q-5);
    end else w(Q);
    sda_m = b; w(Q); scl = 1'b1;
    if (glitch && b) begin
      w(3); sda_m = 1'b0; w(2); sda_m = 1'b1; w(Q-5);
    end else w(Q);
    seen = sda_line; w(Q); scl = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] v, input bit may_ack, input bit glitch,
                            output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) xfer_bit(v[i], glitch, s);
    allow = may_ack;
    xfer_bit(1'b1, 1'b0, s);
    acked = !s;
    w(8); allow = 1'b0;
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] v);
    bit s;
    for (int i = 7; i >= 0; i--) begin xfer_bit(1'b1, 1'b0, s); v[i] = s; end
    xfer_bit(!mack, 1'b0, s);
    sda_m = 1'b1; w(8);
  endtask

  task automatic write_cmd(input logic [7:0] addr, input logic [15:0] word, input bit glitch);
    bit a;
    write_byte(addr, 1'b1, glitch, a); check(a, "R1 address ack", a, 1);
    write_byte(word[15:8], 1'b1, glitch, a); check(a, "R3 first byte ack", a, 1);
    write_byte(word[7:0], 1'b1, glitch, a); check(a, "R3 second byte ack", a, 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    bit a;
    int p0;
    logic [7:0] v;
    w(3);
    check(sda_oe == 1'b0 && cmd_valid == 1'b0, "R11 reset outputs", {sda_oe, cmd_valid}, 0);
    rst_n = 1'b1; w(5);
    check(cmd == 16'h0, "R11 cmd after reset", cmd, 0);

    // R1 R3 R4: plain write
    p0 = pulses; exp_q.push_back(16'h935C);
    i2c_start(); write_cmd(8'hEA, 16'h935C, 1'b0); i2c_stop();
    check(pulses - p0 == 1, "R4 one strobe", pulses - p0, 1);
    check(cmd == 16'h935C, "R3 cmd held", cmd, 16'h935C);

    // R2: low bits mismatch, following bytes ignored
    p0 = pulses;
    i2c_start(); write_byte(8'hE8, 1'b0, 1'b0, a); check(!a, "R2 no ack mismatch", a, 0);
    write_byte(8'h12, 1'b0, 1'b0, a); write_byte(8'h34, 1'b0, 1'b0, a);
    check(!a, "R2 data ignored", a, 0); i2c_stop();
    check(pulses == p0, "R2 no strobe", pulses - p0, 0);

    // R1: prefix mismatch
    i2c_start(); write_byte(8'h6A, 1'b0, 1'b0, a); check(!a, "R1 prefix mismatch", a, 0); i2c_stop();

    // R5: partial word then STOP
    p0 = pulses;
    i2c_start(); write_byte(8'hEA, 1'b1, 1'b0, a); write_byte(8'h11, 1'b1, 1'b0, a);
    i2c_stop();
    check(pulses == p0, "R5 partial by stop", pulses - p0, 0);

    // R5 R9: partial word then repeated START, then full write
    exp_q.push_back(16'h2244);
    i2c_start(); write_byte(8'hEA, 1'b1, 1'b0, a); write_byte(8'h77, 1'b1, 1'b0, a);
    i2c_start(); write_cmd(8'hEA, 16'h2244, 1'b0); i2c_stop();
    check(pulses - p0 == 1, "R5 R9 restart strobe", pulses - p0, 1);
    check(cmd == 16'h2244, "R5 partial discarded", cmd, 16'h2244);

    // R6: third byte not acked
    p0 = pulses; exp_q.push_back(16'hABCD);
    i2c_start(); write_cmd(8'hEA, 16'hABCD, 1'b0);
    write_byte(8'hEE, 1'b0, 1'b0, a); check(!a, "R6 third byte nack", a, 0); i2c_stop();
    check(pulses - p0 == 1 && cmd == 16'hABCD, "R6 single strobe", pulses - p0, 1);

    // R7: read two bytes
    i2c_start(); write_byte(8'hEB, 1'b1, 1'b0, a); check(a, "R1 read address ack", a, 1);
    allow = 1'b1;
    read_byte(1'b1, v); check(v == 8'h00, "R7 first read byte", v, 0);
    read_byte(1'b0, v); check(v == 8'hA6, "R7 status byte", v, 8'hA6);
    allow = 1'b0; i2c_stop();

    // R8: NACK after first byte ends the read
    status = 8'h3C;
    i2c_start(); write_byte(8'hEB, 1'b1, 1'b0, a);
    allow = 1'b1; read_byte(1'b0, v); allow = 1'b0;
    check(v == 8'h00, "R7 zero byte again", v, 0);
    read_byte(1'b0, v); check(v == 8'hFF, "R8 released after nack", v, 8'hFF);
    i2c_stop();

    // R9: repeated START after rejected address
    p0 = pulses; exp_q.push_back(16'h0102);
    i2c_start(); write_byte(8'hE6, 1'b0, 1'b0, a); check(!a, "R9 first address rejected", a, 0);
    i2c_start(); write_cmd(8'hEA, 16'h0102, 1'b0); i2c_stop();
    check(pulses - p0 == 1, "R9 strobe after restart", pulses - p0, 1);

    // R1: strap change
    pins = 3'b000; w(4);
    i2c_start(); write_byte(8'hEA, 1'b0, 1'b0, a); check(!a, "R1 old address refused", a, 0); i2c_stop();
    p0 = pulses; exp_q.push_back(16'h8001);
    i2c_start(); write_cmd(8'hE0, 16'h8001, 1'b0); i2c_stop();
    check(pulses - p0 == 1, "R1 new strap strobe", pulses - p0, 1);

    // R10: short spikes on both lines
    p0 = pulses; exp_q.push_back(16'hF00F);
    i2c_start(); write_cmd(8'hE0, 16'hF00F, 1'b1); i2c_stop();
    check(pulses - p0 == 1 && cmd == 16'hF00F, "R10 spikes ignored", cmd, 16'hF00F);

    check(viol == 0, "R2 R12 drive outside window", viol, 0);
    check(exp_q.size() == 0, "R4 missing strobes", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule